// File: doc/BRIEF.md
# Mode-Configurable PLD Output Cell

This block is a single output cell of a small sum-of-products logic device. It receives the eight product-term results that the AND array computes for it, plus the device clock pin, an active-low output-enable pin and the value currently present on its own I/O pad. From these inputs it produces three signals: the value to drive onto the pad, a tristate enable for the pad driver, and the signal that goes back into the array as feedback. Eight of these cells and the array together form a complete device.

A two-bit global mode field is common to all cells. It selects Simple, Complex or Registered behaviour. Two local bits complete the setup of each cell. One sets the output polarity. The other chooses between the register and the combinatorial path, and in Simple mode it chooses between a driven output and a dedicated input. Together the mode and local bits decide three things: how many terms are ORed, whether the pad enable comes from a constant, a product term or the OE pin, and whether feedback comes from the pad or from the register. The register holds a D flip-flop that reset clears. It is clocked by the clock pin.

Top module: `pld_out_cell`

## Requirements
- R1: The global mode encodes as 2'b01 Simple, 2'b10 Complex and 2'b11 Registered. The encoding 2'b00 is undefined: it forces pin_oe_o and pin_o low and takes feedback from the pad.
- R2: In every combinatorial configuration, pol_hi_i=1 drives the OR result onto pin_o unchanged and pol_hi_i=0 drives its complement.
- R3: In Simple mode with reg_sel_i=0, pin_o is the OR of all eight terms (polarity applied) and pin_oe_o is held at 1.
- R4: In Simple mode with reg_sel_i=1, pin_oe_o is 0 for any term pattern and fb_o follows pad_i.
- R5: In Complex mode, pin_o is the OR of terms 0..6 (polarity applied), term 7 has no effect on pin_o, pin_oe_o equals term 7, and fb_o follows pad_i.
- R6: In Registered mode with reg_sel_i=0, the cell behaves as in R5.
- R7: In Registered mode with reg_sel_i=1, the register loads the OR of all eight terms on every rising clock edge. pin_o then shows the register output, inverted when pol_hi_i=0, from that edge on, and a change in the terms between edges does not reach pin_o.
- R8: In Registered mode with reg_sel_i=1, pin_oe_o is the inverse of oe_pin_n_i, with no clock delay.
- R9: In Registered mode with reg_sel_i=1, fb_o is the register's true output for either polarity and ignores pad_i.
- R10: A low rst_n at a clock edge clears the register. Before the next loading edge, a registered active-high pin reads 0 and a registered active-low pin reads 1.
- R11: Outside Registered-with-register operation, oe_pin_n_i has no effect on pin_oe_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock pin; clocks the cell register |
| rst_n | input | 1 | Synchronous active-low reset, models power-up clear |
| gmode_i | input | 2 | Global device mode (shared by all cells) |
| pol_hi_i | input | 1 | 1 = active-high output, 0 = active-low |
| reg_sel_i | input | 1 | Local register/combinatorial (or input-only in Simple) select |
| terms_i | input | NTERM | Product-term results from the array; top bit is the control term |
| oe_pin_n_i | input | 1 | Active-low output-enable pin |
| pad_i | input | 1 | Value present on the I/O pad |
| pin_o | output | 1 | Value driven toward the pad |
| pin_oe_o | output | 1 | Pad driver enable |
| fb_o | output | 1 | Feedback signal to the array |

## Verification
The bench targets term 7, which plays a double role. It is an ordinary OR input in Simple and registered operation, but it becomes the enable in Complex and Registered-combinatorial operation. A design that mixes up those roles either lets term 7 switch pin_o or leaves the pad always driven. A second target is the registered path. The bench changes terms between clock edges and checks that pin_o holds, then checks the value straight after reset under both polarities. A cell that bypasses the register, or that applies polarity before the flip-flop, shows a wrong pin level or a wrong fb_o. The undefined mode code and the OE pin outside Registered mode are also exercised. A decoder that falls through to a default would drive the pad in those cases.

// File: rtl/pld_out_cell_pkg.sv
// Shared types for the output cell: global mode codes, enable-source
// choices and the decoded control bundle passed from decoder to datapath.
package pld_out_cell_pkg;

    typedef enum logic [1:0] {
        GM_UNDEF   = 2'b00,
        GM_SIMPLE  = 2'b01,
        GM_COMPLEX = 2'b10,
        GM_REG     = 2'b11
    } gmode_e;

    typedef enum logic [1:0] {
        OE_OFF  = 2'b00,
        OE_ON   = 2'b01,
        OE_TERM = 2'b10,
        OE_PIN  = 2'b11
    } oe_src_e;

    typedef struct packed {
        logic    use_all_terms;  // OR all terms (else drop the control term)
        logic    out_from_reg;   // pin value taken from the register
        logic    fb_from_reg;    // feedback taken from the register
        logic    out_kill;       // force pin value low
        oe_src_e oe_src;         // where the pad enable comes from
    } cell_ctrl_t;

endpackage

// File: rtl/pld_out_cell_decode.sv
// Mode decoder: turns the global mode field and the local register select
// into the control bundle. Pure combinational; assumes the configuration is
// static while the cell is in use.
module pld_out_cell_decode
    import pld_out_cell_pkg::*;
(
    input  logic [1:0] gmode_i,
    input  logic       reg_sel_i,
    output cell_ctrl_t ctrl_o
);

    gmode_e mode;
    assign mode = gmode_e'(gmode_i);

    // Map each mode/local-bit combination to its datapath controls.
    always_comb begin
        ctrl_o = '{use_all_terms: 1'b0, out_from_reg: 1'b0,
                   fb_from_reg: 1'b0, out_kill: 1'b1, oe_src: OE_OFF};
        case (mode)
            GM_SIMPLE: begin
                ctrl_o.use_all_terms = 1'b1;
                ctrl_o.out_kill      = 1'b0;
                ctrl_o.oe_src        = reg_sel_i ? OE_OFF : OE_ON;
            end
            GM_COMPLEX: begin
                ctrl_o.out_kill = 1'b0;
                ctrl_o.oe_src   = OE_TERM;
            end
            GM_REG: begin
                ctrl_o.out_kill = 1'b0;
                if (reg_sel_i) begin
                    ctrl_o.use_all_terms = 1'b1;
                    ctrl_o.out_from_reg  = 1'b1;
                    ctrl_o.fb_from_reg   = 1'b1;
                    ctrl_o.oe_src        = OE_PIN;
                end else begin
                    ctrl_o.oe_src = OE_TERM;
                end
            end
            default: begin
                ctrl_o.oe_src = OE_OFF;
            end
        endcase
    end

endmodule

// File: rtl/pld_out_cell_terms.sv
// Fixed-OR stage: a prefix-OR chain over the product terms gives both the
// full sum and the sum without the top (control) term. Assumes NTERM >= 2.
module pld_out_cell_terms #(
    parameter int NTERM = 8
) (
    input  logic [NTERM-1:0] terms_i,
    output logic             sum_all_o,
    output logic             sum_part_o,
    output logic             ctl_term_o
);

    localparam int TOP = NTERM - 1;

    logic [NTERM-1:0] acc;

    assign acc[0] = terms_i[0];

    // Build the running OR, one stage per term.
    for (genvar i = 1; i < NTERM; i++) begin : g_or
        assign acc[i] = acc[i-1] | terms_i[i];
    end

    assign sum_all_o  = acc[TOP];
    assign sum_part_o = acc[TOP-1];
    assign ctl_term_o = terms_i[TOP];

endmodule

// File: rtl/pld_out_cell_reg.sv
// Cell flip-flop: loads the full OR every rising edge of the clock pin and
// clears on a synchronous active-low reset (power-up clear model).
module pld_out_cell_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    // Capture the sum, or clear during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= 1'b0;
        else        q_o <= d_i;
    end

endmodule

// File: rtl/pld_out_cell.sv
// Output cell top: decodes the mode, forms the OR sums, holds the register
// and selects pin value, pad enable and feedback. Assumes the mode and local
// bits are static configuration; pad_i is the resolved pad level.
module pld_out_cell
    import pld_out_cell_pkg::*;
#(
    parameter int NTERM = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       gmode_i,
    input  logic             pol_hi_i,
    input  logic             reg_sel_i,
    input  logic [NTERM-1:0] terms_i,
    input  logic             oe_pin_n_i,
    input  logic             pad_i,
    output logic             pin_o,
    output logic             pin_oe_o,
    output logic             fb_o
);

    cell_ctrl_t ctrl;
    logic       sum_all;
    logic       sum_part;
    logic       ctl_term;
    logic       q;
    logic       core;

    pld_out_cell_decode u_dec (
        .gmode_i   (gmode_i),
        .reg_sel_i (reg_sel_i),
        .ctrl_o    (ctrl)
    );

    pld_out_cell_terms #(.NTERM(NTERM)) u_terms (
        .terms_i    (terms_i),
        .sum_all_o  (sum_all),
        .sum_part_o (sum_part),
        .ctl_term_o (ctl_term)
    );

    pld_out_cell_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (sum_all),
        .q_o   (q)
    );

    // Choose the uninverted output source.
    always_comb begin
        if (ctrl.out_from_reg)       core = q;
        else if (ctrl.use_all_terms) core = sum_all;
        else                         core = sum_part;
    end

    // Apply polarity, or hold low in the undefined mode.
    always_comb begin
        if (ctrl.out_kill) pin_o = 1'b0;
        else               pin_o = pol_hi_i ? core : ~core;
    end

    // Select the pad enable source.
    always_comb begin
        case (ctrl.oe_src)
            OE_ON:   pin_oe_o = 1'b1;
            OE_TERM: pin_oe_o = ctl_term;
            OE_PIN:  pin_oe_o = ~oe_pin_n_i;
            default: pin_oe_o = 1'b0;
        endcase
    end

    // Feedback from the register true output or from the pad.
    always_comb begin
        fb_o = ctrl.fb_from_reg ? q : pad_i;
    end

endmodule

// File: rtl/pld_out_cell_chk.sv
// Property checker for the output cell, attached by bind below.
module pld_out_cell_chk #(
    parameter int NTERM = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       gmode_i,
    input logic             pol_hi_i,
    input logic             reg_sel_i,
    input logic [NTERM-1:0] terms_i,
    input logic             oe_pin_n_i,
    input logic             pad_i,
    input logic             pin_o,
    input logic             pin_oe_o,
    input logic             fb_o
);

    localparam int TOP = NTERM - 1;

    logic reg_on;
    assign reg_on = (gmode_i == 2'b11) && reg_sel_i;

    assert_undef_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (gmode_i == 2'b00) |-> (!pin_oe_o && !pin_o && fb_o == pad_i));

    assert_simple_out_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (gmode_i == 2'b01 && !reg_sel_i) |-> pin_oe_o);

    assert_simple_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (gmode_i == 2'b01 && reg_sel_i) |-> (!pin_oe_o && fb_o == pad_i));

    assert_complex_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (gmode_i == 2'b10) |-> (pin_oe_o == terms_i[TOP] && fb_o == pad_i));

    assert_regcomb_oe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gmode_i == 2'b11 && !reg_sel_i) |-> (pin_oe_o == terms_i[TOP]));

    assert_reg_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_on && $past(rst_n) && $past(reg_on)) |-> (fb_o == $past(|terms_i)));

    assert_reg_oe_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_on |-> (pin_oe_o == !oe_pin_n_i));

    assert_reg_fb_pol_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_on |-> (pin_o == (pol_hi_i ? fb_o : !fb_o)));

    assert_reset_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_on && !$past(rst_n)) |-> (fb_o == 1'b0));

endmodule

bind pld_out_cell pld_out_cell_chk #(.NTERM(NTERM)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gmode_i    (gmode_i),
    .pol_hi_i   (pol_hi_i),
    .reg_sel_i  (reg_sel_i),
    .terms_i    (terms_i),
    .oe_pin_n_i (oe_pin_n_i),
    .pad_i      (pad_i),
    .pin_o      (pin_o),
    .pin_oe_o   (pin_oe_o),
    .fb_o       (fb_o)
);

// File: tb/pld_out_cell_tb_top.sv
// Directed bench for the output cell: one task per scenario.
module pld_out_cell_tb_top;

    localparam int NTERM = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       gmode = 2'b00;
    logic             pol = 1'b1;
    logic             rsel = 1'b0;
    logic [NTERM-1:0] terms = '0;
    logic             oe_n = 1'b1;
    logic             pad = 1'b0;
    logic             pin_o, pin_oe, fb;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pld_out_cell #(.NTERM(NTERM)) dut_i (
        .clk(clk), .rst_n(rst_n), .gmode_i(gmode), .pol_hi_i(pol),
        .reg_sel_i(rsel), .terms_i(terms), .oe_pin_n_i(oe_n), .pad_i(pad),
        .pin_o(pin_o), .pin_oe_o(pin_oe), .fb_o(fb)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Settle combinational paths after an input change on the falling edge.
    task automatic settle();
        #1;
    endtask

    task automatic next_neg();
        @(negedge clk);
    endtask

    task automatic t_reset();
        next_neg();
        gmode = 2'b11; rsel = 1'b1; pol = 1'b1; terms = '1; rst_n = 1'b0;
        next_neg(); settle();
        chk("R10", "active-high pin after clear", pin_o, 1'b0);
        chk("R10", "fb after clear", fb, 1'b0);
        pol = 1'b0; settle();
        chk("R10", "active-low pin after clear", pin_o, 1'b1);
        rst_n = 1'b1; settle();
        chk("R10", "pin holds before first load", pin_o, 1'b1);
        next_neg(); settle();
        chk("R7", "register loaded after edge", fb, 1'b1);
    endtask

    task automatic t_undef();
        next_neg();
        gmode = 2'b00; rsel = 1'b1; terms = '1; pol = 1'b1; oe_n = 1'b0; pad = 1'b1; settle();
        chk("R1", "undefined mode oe", pin_oe, 1'b0);
        chk("R1", "undefined mode pin", pin_o, 1'b0);
        chk("R1", "undefined mode fb", fb, 1'b1);
    endtask

    task automatic t_simple_out();
        next_neg();
        gmode = 2'b01; rsel = 1'b0; pol = 1'b1; terms = 8'h80; oe_n = 1'b0; settle();
        chk("R3", "term 7 alone drives pin", pin_o, 1'b1);
        chk("R3", "oe always on", pin_oe, 1'b1);
        oe_n = 1'b1; settle();
        chk("R11", "oe pin ignored in Simple", pin_oe, 1'b1);
        terms = '0; settle();
        chk("R3", "no term active", pin_o, 1'b0);
        pol = 1'b0; settle();
        chk("R2", "active-low inverts", pin_o, 1'b1);
        terms = 8'h04; settle();
        chk("R2", "active-low with term", pin_o, 1'b0);
    endtask

    task automatic t_simple_in();
        next_neg();
        gmode = 2'b01; rsel = 1'b1; pol = 1'b1; terms = '1; pad = 1'b0; settle();
        chk("R4", "input-only oe", pin_oe, 1'b0);
        chk("R4", "fb follows pad low", fb, 1'b0);
        pad = 1'b1; terms = '0; settle();
        chk("R4", "fb follows pad high", fb, 1'b1);
        chk("R4", "oe still off", pin_oe, 1'b0);
    endtask

    task automatic t_complex();
        next_neg();
        gmode = 2'b10; rsel = 1'b0; pol = 1'b1; oe_n = 1'b0; pad = 1'b0;
        terms = 8'h80; settle();
        chk("R5", "term 7 not in OR", pin_o, 1'b0);
        chk("R5", "term 7 enables pad", pin_oe, 1'b1);
        chk("R5", "fb from pad", fb, 1'b0);
        terms = 8'h40; settle();
        chk("R5", "term 6 in OR", pin_o, 1'b1);
        chk("R5", "term 7 low disables", pin_oe, 1'b0);
        chk("R11", "oe pin ignored in Complex", pin_oe, 1'b0);
        rsel = 1'b1; pad = 1'b1; settle();
        chk("R5", "local select ignored", pin_oe, 1'b0);
        chk("R5", "fb from pad with select", fb, 1'b1);
        pol = 1'b0; terms = 8'h81; settle();
        chk("R2", "Complex active-low", pin_o, 1'b0);
    endtask

    task automatic t_reg_comb();
        next_neg();
        gmode = 2'b11; rsel = 1'b0; pol = 1'b1; oe_n = 1'b0; pad = 1'b1;
        terms = 8'h80; settle();
        chk("R6", "term 7 not in OR", pin_o, 1'b0);
        chk("R6", "term 7 enables pad", pin_oe, 1'b1);
        chk("R6", "fb from pad", fb, 1'b1);
        terms = 8'h01; settle();
        chk("R6", "term 0 in OR", pin_o, 1'b1);
        chk("R11", "oe pin ignored in reg-comb", pin_oe, 1'b0);
    endtask

    task automatic t_reg_reg();
        next_neg();
        gmode = 2'b11; rsel = 1'b1; pol = 1'b1; oe_n = 1'b1; pad = 1'b1; terms = '0;
        next_neg(); settle();
        chk("R7", "register loads zero", pin_o, 1'b0);
        chk("R9", "fb true output, pad ignored", fb, 1'b0);
        chk("R8", "oe pin high disables", pin_oe, 1'b0);
        oe_n = 1'b0; settle();
        chk("R8", "oe pin low enables", pin_oe, 1'b1);
        terms = 8'h80; settle();
        chk("R7", "pin holds between edges", pin_o, 1'b0);
        next_neg(); settle();
        chk("R7", "term 7 loaded", pin_o, 1'b1);
        pol = 1'b0; settle();
        chk("R7", "active-low registered pin", pin_o, 1'b0);
        chk("R9", "fb unaffected by polarity", fb, 1'b1);
        pad = 1'b0; terms = '0; settle();
        chk("R9", "fb ignores pad", fb, 1'b1);
        next_neg(); settle();
        chk("R7", "reload zero active-low", pin_o, 1'b1);
    endtask

    initial begin
        t_reset();
        t_undef();
        t_simple_out();
        t_simple_in();
        t_complex();
        t_reg_comb();
        t_reg_reg();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule